// File: doc/BRIEF.md
# Fractional Microsecond Tick Counter

This block derives a 1 MHz event stream from a faster reference clock. The division ratio is a fraction, not an integer. A configuration register holds an encoded numerator and denominator. An accumulator adds the numerator on every reference cycle. It emits a one-cycle tick whenever it reaches the denominator. Reference clocks whose frequency is not a whole number of megahertz therefore still average exactly one tick per microsecond. For example, 19.2 MHz uses the fraction 5/96.

Each tick also advances a free-running microsecond counter. Software reads that counter through a plain single-cycle register port: write enable, address, write data and combinational read data. A hold control stops both the accumulator and the counter, for example while a debugger has the system halted. Other timers in the chip use the tick output as their time base.

Top module: `usec_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the ratio register reads 0x0000000B, the counter reads 0, the hold control reads 0 and the tick output is low.
- R2: The ratio register sits at offset 0x14. Bits [7:0] hold the denominator minus one, bits [15:8] hold the numerator minus one, and bits [31:16] read as zero whatever was written.
- R3: On each cycle that is neither held nor a ratio write, the accumulator adds the numerator. When the sum reaches the denominator, the denominator is subtracted and the tick output is high for the one cycle after that clock edge. So 0x000B ticks every 12th cycle, 0x000C every 13th, 0x0019 every 26th, and 0x045F exactly 5 times in any 96 consecutive cycles.
- R4: When the numerator is greater than or equal to the denominator, the block ticks on every unheld, non-write cycle and the accumulator stays at zero.
- R5: The counter at offset 0x10 grows by exactly one on the clock edge that raises a tick, and is otherwise unchanged.
- R6: The counter wraps from its all-ones value to zero with no other effect.
- R7: The hold control is bit 0 at offset 0x4C. From the cycle after a 1 is written, the counter and accumulator keep their values and no tick occurs, until a 0 is written.
- R8: A write to the ratio register clears the accumulator, produces no tick in that cycle and leaves the counter unchanged. This also applies while held.
- R9: Writes to the counter offset and to unmapped offsets change nothing, and unmapped offsets read as zero.
- R10: Read data follows the address in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |
| us_tick_o | output | 1 | One-cycle microsecond tick |

## Verification
A ratio or hold write takes effect at the clock edge that samples it. A tick caused by the sum at an edge appears on the tick output just after that edge. The counter's new value shows on the read port in the same cycle as the tick. Read data depends only on the current address and the registered state, so it settles within the same cycle. The driver pushes one expected tick and read value per edge from a model of these rules. The monitor compares them 1 ns after that edge, before the next inputs are driven on the falling edge, so every comparison lands in the cycle where the result is due.

// File: rtl/utick_pkg.sv
// Shared constants and types for the fractional microsecond tick counter.
// Assumes byte offsets of 8 bits and a 32-bit register port.
package utick_pkg;
    localparam int FIELD_W = 8;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RATIO = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_HOLD  = 8'h4C;

    // Numerator in the upper byte, denominator in the lower byte.
    typedef struct packed {
        logic [FIELD_W-1:0] num_m1;
        logic [FIELD_W-1:0] den_m1;
    } ratio_cfg_t;

    localparam ratio_cfg_t RATIO_RESET = '{num_m1: 8'h00, den_m1: 8'h0B};
endpackage

// File: rtl/utick_regs.sv
// Register file: ratio configuration, hold control and the read mux.
// Assumes single-cycle writes; reads are combinational on the address.
module utick_regs
    import utick_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output ratio_cfg_t        cfg_o,
    output logic              hold_o,
    output logic              cfg_wr_o,
    output logic [REG_W-1:0]  rdata_o
);
    localparam int CFG_W = $bits(ratio_cfg_t);

    ratio_cfg_t       cfg_q;
    logic             hold_q;
    logic [REG_W-1:0] cnt_ext;
    logic             unused_wbits;

    assign unused_wbits = ^{wdata_i[REG_W-1:CFG_W], wdata_i[CFG_W-1:1]};

    // Fit the counter to the register width.
    generate
        if (CNT_W < REG_W) begin : g_pad
            assign cnt_ext = {{(REG_W-CNT_W){1'b0}}, cnt_i};
        end else begin : g_trim
            assign cnt_ext = cnt_i[REG_W-1:0];
        end
    endgenerate

    // Pulse that restarts the accumulator when the ratio is rewritten.
    assign cfg_wr_o = we_i && (addr_i == OFS_RATIO);

    // Hold the configuration and hold-control state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q  <= RATIO_RESET;
            hold_q <= 1'b0;
        end else begin
            if (cfg_wr_o) cfg_q <= ratio_cfg_t'(wdata_i[CFG_W-1:0]);
            if (we_i && addr_i == OFS_HOLD) hold_q <= wdata_i[0];
        end
    end

    // Select the read value for the current address.
    always_comb begin
        unique case (addr_i)
            OFS_COUNT: rdata_o = cnt_ext;
            OFS_RATIO: rdata_o = {{(REG_W-CFG_W){1'b0}}, cfg_q};
            OFS_HOLD:  rdata_o = {{(REG_W-1){1'b0}}, hold_q};
            default:   rdata_o = '0;
        endcase
    end

    assign cfg_o  = cfg_q;
    assign hold_o = hold_q;

    // R2: the ratio register takes the written low half at the next edge.
    assert_ratio_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_wr_o |=> (cfg_o == ratio_cfg_t'($past(wdata_i[CFG_W-1:0]))));
    // R9: no write touches the ratio register except one at its offset.
    assert_ratio_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_wr_o |=> $stable(cfg_o));
endmodule

// File: rtl/utick_ratio.sv
// Fractional accumulator: adds the numerator each cycle, ticks on reaching
// the denominator. Assumes the numerator/denominator fit in FIELD_W+1 bits.
module utick_ratio
    import utick_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  ratio_cfg_t cfg_i,
    input  logic       hold_i,
    input  logic       clr_i,
    output logic       step_o,
    output logic       tick_o
);
    localparam int ACC_W = FIELD_W + 1;
    localparam int SUM_W = FIELD_W + 2;

    logic [ACC_W-1:0] acc_q, acc_d;
    logic [ACC_W-1:0] num, den;
    logic [SUM_W-1:0] sum;
    logic             full_rate, hit, tick_q;

    // Decode the ratio and form the next accumulator value.
    always_comb begin
        num       = ACC_W'(cfg_i.num_m1) + ACC_W'(1);
        den       = ACC_W'(cfg_i.den_m1) + ACC_W'(1);
        sum       = SUM_W'(acc_q) + SUM_W'(num);
        full_rate = (num >= den);
        hit       = 1'b0;
        acc_d     = acc_q;
        if (clr_i) begin
            acc_d = '0;
        end else if (hold_i) begin
            acc_d = acc_q;
        end else if (full_rate) begin
            hit   = 1'b1;
            acc_d = '0;
        end else if (sum >= SUM_W'(den)) begin
            hit   = 1'b1;
            acc_d = ACC_W'(sum - SUM_W'(den));
        end else begin
            acc_d = ACC_W'(sum);
        end
    end

    // Register the accumulator and the tick.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            tick_q <= hit;
        end
    end

    assign step_o = hit;
    assign tick_o = tick_q;

    // R3: the remainder always stays below the denominator.
    assert_acc_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_q < den);
    // R7: a held cycle neither ticks nor moves the accumulator.
    assert_hold_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_i && !clr_i) |=> (!tick_o && $stable(acc_q)));
    // R8: a ratio write restarts the accumulator without a tick.
    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (acc_q == '0 && !tick_o));
    // R4: numerator at or above the denominator ticks every free cycle.
    assert_full_rate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !hold_i && full_rate) |=> tick_o);
endmodule

// File: rtl/utick_counter.sv
// Free-running microsecond counter; advances once per accepted step and
// wraps silently. Assumes the step input is a single-cycle strobe.
module utick_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count steps, wrapping at the width.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (step_i) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o = cnt_q;

    // R5: no step, no change.
    assert_idle_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(cnt_o));
    // R6: a step from all-ones lands on zero.
    assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && (&cnt_o)) |=> (cnt_o == '0));
endmodule

// File: rtl/usec_tick_timer.sv
// Top level: register port, fractional accumulator and microsecond counter.
// Assumes one reference clock domain and a synchronous active-low reset.
module usec_tick_timer
    import utick_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_we_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    output logic [REG_W-1:0]     reg_rdata_o,
    output logic                 us_tick_o
);
    ratio_cfg_t       cfg;
    logic             hold, cfg_wr, step;
    logic [CNT_W-1:0] cnt;

    utick_regs #(.CNT_W(CNT_W)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (reg_we_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .cnt_i    (cnt),
        .cfg_o    (cfg),
        .hold_o   (hold),
        .cfg_wr_o (cfg_wr),
        .rdata_o  (reg_rdata_o)
    );

    utick_ratio u_ratio (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cfg_i  (cfg),
        .hold_i (hold),
        .clr_i  (cfg_wr),
        .step_o (step),
        .tick_o (us_tick_o)
    );

    utick_counter #(.CNT_W(CNT_W)) u_count (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (step),
        .cnt_o  (cnt)
    );

    // R5: the counter moves by one exactly when a tick appears.
    assert_count_tracks_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        us_tick_o |-> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: tb/test_usec_tick_timer.sv
`timescale 1ns/1ps
module test_usec_tick_timer;
    localparam logic [7:0] A_CNT = 8'h10, A_RAT = 8'h14, A_HLD = 8'h4C, A_BAD = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = A_CNT;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        tick;
    logic        n_we = 1'b0;
    logic [7:0]  n_addr = A_CNT;
    logic [31:0] n_wd = '0;
    logic [31:0] n_rd;
    logic        n_tick;

    always #2.5 clk = ~clk;

    usec_tick_timer i_usec_tick_timer (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wd), .reg_rdata_o(rd), .us_tick_o(tick));

    usec_tick_timer #(.CNT_W(8)) i_usec_tick_timer_narrow (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(n_we), .reg_addr_i(n_addr),
        .reg_wdata_i(n_wd), .reg_rdata_o(n_rd), .us_tick_o(n_tick));

    int checks = 0, fails = 0;
    bit done = 0;
    string cur_tag = "R1";

    // Scoreboard queues, one entry per clock edge.
    bit          q_tick[$];
    logic [31:0] q_rd[$];
    string       q_tag[$];

    // Behavioural model state.
    logic [15:0] m_cfg = 16'h000B;
    int          m_acc = 0;
    logic [31:0] m_cnt = '0;
    bit          m_hold = 0;
    bit          m_tick = 0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(logic [7:0] a);
        case (a)
            A_CNT:   return m_cnt;
            A_RAT:   return {16'h0, m_cfg};
            A_HLD:   return {31'h0, m_hold};
            default: return 32'h0;
        endcase
    endfunction

    // Advance the model over the coming edge.
    task automatic model_step(bit r, bit w, logic [7:0] a, logic [31:0] d);
        int num, den, s;
        if (!r) begin
            m_cfg = 16'h000B; m_acc = 0; m_cnt = '0; m_hold = 0; m_tick = 0;
        end else if (w && a == A_RAT) begin
            m_cfg = d[15:0]; m_acc = 0; m_tick = 0;
        end else begin
            m_tick = 0;
            if (!m_hold) begin
                num = int'(m_cfg[15:8]) + 1;
                den = int'(m_cfg[7:0]) + 1;
                s = m_acc + num;
                if (num >= den) begin
                    m_tick = 1; m_acc = 0;
                end else if (s >= den) begin
                    m_tick = 1; m_acc = s - den;
                end else begin
                    m_acc = s;
                end
                if (m_tick) m_cnt = m_cnt + 32'd1;
            end
            if (w && a == A_HLD) m_hold = d[0];
        end
    endtask

    // Driver: one cycle of stimulus plus its expected result.
    task automatic drive(bit r, bit w, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        rst_n = r; we = w; addr = a; wd = d;
        model_step(r, w, a, d);
        q_tick.push_back(m_tick);
        q_rd.push_back(model_read(a));
        q_tag.push_back(cur_tag);
    endtask

    task automatic idle(int n, logic [7:0] a);
        for (int i = 0; i < n; i++) drive(1, 0, a, 32'h0);
    endtask

    // Monitor: compare just after each edge.
    always @(posedge clk) begin
        #1;
        if (q_tick.size() > 0) begin
            string t;
            t = q_tag.pop_front();
            check(t, "tick", {31'h0, tick}, {31'h0, q_tick.pop_front()});
            check(t, "rdata", rd, q_rd.pop_front());
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] c0, c1;
        // R1: reset state.
        cur_tag = "R1";
        for (int i = 0; i < 4; i++) drive(0, 0, A_CNT, 0);
        drive(1, 0, A_RAT, 0);
        drive(1, 0, A_HLD, 0);
        // R3 and R5: default ratio, counter tracks ticks.
        cur_tag = "R3_R5";
        idle(40, A_CNT);
        // R2: upper bits discarded on the 5/96 ratio.
        cur_tag = "R2";
        drive(1, 1, A_RAT, 32'hFFFF_045F);
        drive(1, 0, A_RAT, 0);
        cur_tag = "R3";
        drive(1, 0, A_CNT, 0);
        @(posedge clk); #1; c0 = rd;
        idle(96, A_CNT);
        @(posedge clk); #1; c1 = rd;
        check("R3", "ticks per 96 cycles", c1 - c0, 32'd5);
        idle(100, A_CNT);
        drive(1, 1, A_RAT, 32'h0000_0019);
        idle(60, A_CNT);
        drive(1, 1, A_RAT, 32'h0000_000C);
        idle(30, A_CNT);
        // R4: numerator above and equal to the denominator.
        cur_tag = "R4";
        drive(1, 1, A_RAT, 32'h0000_0300);
        idle(10, A_CNT);
        drive(1, 1, A_RAT, 32'h0000_0505);
        idle(10, A_CNT);
        // R9: writes to the counter and unmapped offsets are ignored.
        cur_tag = "R9";
        drive(1, 1, A_CNT, 32'h0);
        drive(1, 1, A_BAD, 32'hFFFF_FFFF);
        drive(1, 0, A_BAD, 0);
        idle(3, A_CNT);
        drive(1, 0, A_RAT, 0);
        // R10: read follows the address each cycle.
        cur_tag = "R10";
        drive(1, 1, A_RAT, 32'h0000_000B);
        for (int i = 0; i < 12; i++) drive(1, 0, (i % 3 == 0) ? A_CNT : (i % 3 == 1) ? A_RAT : A_HLD, 0);
        // R7: hold freezes everything.
        cur_tag = "R7";
        drive(1, 1, A_HLD, 32'h1);
        idle(30, A_CNT);
        drive(1, 0, A_HLD, 0);
        // R8: ratio write while held, then release.
        cur_tag = "R8";
        drive(1, 1, A_RAT, 32'h0000_000B);
        cur_tag = "R7";
        drive(1, 1, A_HLD, 32'h0);
        idle(30, A_CNT);
        // R8: rewrite mid-accumulation restarts the 12-cycle spacing.
        cur_tag = "R8";
        idle(7, A_CNT);
        drive(1, 1, A_RAT, 32'h0000_000B);
        idle(30, A_CNT);
        // R6: narrow counter wraps.
        @(negedge clk); n_we = 1; n_addr = A_RAT; n_wd = 32'h0;
        @(negedge clk); n_we = 0; n_addr = A_CNT;
        @(posedge clk); #1; c0 = n_rd;
        repeat (300) @(posedge clk);
        #1; c1 = n_rd;
        check("R6", "wrapped count", c1, (c0 + 32'd300) & 32'hFF);
        check("R6", "upper read bits", c1 & 32'hFFFF_FF00, 32'h0);
        // Drain and report.
        while (q_tick.size() > 0) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule